// File: doc/BRIEF.md
# Sixteen-Bit Timer Counter with Clear-on-Match Modes

This block is the counting core of a 16-bit timer. A prescaler elsewhere supplies a one-cycle `tick` enable, and the counter advances by one on each tick. A four-bit mode selects what the count is compared against as its TOP value. The choices are the all-ones value (free running), compare register A, or the capture register. When the count reaches TOP it returns to zero. Any mode outside the three supported ones stops counting.

On every counted tick, the present count is compared with three compare values and with TOP. Each event sets one bit in a byte-wide flag register, but only if the matching bit in the interrupt mask is 1. Five registered interrupt lines follow the flags under the mask. A software write to the counter loads it immediately and blocks every event on the tick that follows. Software may overwrite the flag register at any time. A power-reduction input holds the whole block in reset.

Top module: `timer16_core`

## Requirements
- R1: While `rst` or `pwr_off` is high, the block clears `count` and `flags` and drives all five interrupt lines low at the next edge. After release, the count stays at 0 until a tick or a write.
- R2: In a running mode, each cycle with `tick` high (and no counter write) advances `count` by one unless a TOP event occurs. Without a tick the count holds.
- R3: The mode is {`mode_hi`,`mode_lo`}. In mode 0, a tick at count 0xFFFF moves the count to 0 and sets overflow flag bit 0.
- R4: In mode 4, a tick while the count equals `cmp_a` clears the count to 0 and sets compare-A flag bit 1.
- R5: In mode 12, a tick while the count equals `cap_val` clears the count to 0 and sets capture flag bit 5. A match with `cmp_a` in this mode sets bit 1 without clearing the count.
- R6: In any running mode, a tick while the count equals `cmp_b` or `cmp_c` sets flag bit 2 or bit 3 respectively. The count advances normally.
- R7: An event whose `irq_mask` bit (same bit position as its flag) is 0 leaves that flag unchanged.
- R8: Each interrupt line equals its flag bit ANDed with the mask bit of the previous cycle. The lines are `irq_ovf` (bit 0), `irq_cmpa` (bit 1), `irq_cmpb` (bit 2), `irq_cmpc` (bit 3) and `irq_capt` (bit 5).
- R9: `cnt_wr` loads `cnt_wdata` into the count at the next edge, and any tick in that cycle is ignored. The next counted tick raises no event and does not clear the count, even if the written value equals a compare value or TOP. The count still advances on that tick.
- R10: Modes other than 0, 4 and 12 hold the count on every tick and raise no events.
- R11: `flag_wr` replaces the flag register with `flag_wdata`. Bits 4, 6 and 7 always read 0. Events in the same cycle are ORed on top of the written value.
- R12: Several events on one tick all set their flags at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_off | input | 1 | Power-reduction request; holds the block in reset |
| tick | input | 1 | Prescaled count enable, one cycle per step |
| mode_lo | input | 2 | Mode bits 1:0 |
| mode_hi | input | 2 | Mode bits 3:2 |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Value loaded into the counter |
| cmp_a | input | 16 | Compare value A (TOP in mode 4) |
| cmp_b | input | 16 | Compare value B |
| cmp_c | input | 16 | Compare value C |
| cap_val | input | 16 | Capture register value (TOP in mode 12) |
| irq_mask | input | 8 | Interrupt mask, same layout as the flags |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | 8 | Value written to the flag register |
| count | output | 16 | Current counter value |
| flags | output | 8 | Interrupt flag register |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_cmpa | output | 1 | Compare A interrupt |
| irq_cmpb | output | 1 | Compare B interrupt |
| irq_cmpc | output | 1 | Compare C interrupt |
| irq_capt | output | 1 | Capture-TOP interrupt |

## Verification
A wrong count shows on `count` at the edge of the very next tick. A wrong TOP selection or a missed clear shows within one tick of the compare value being reached. The blocking state after a counter write is invisible except on the following tick, so the checks preload counts exactly on a compare value or TOP and look for a missing clear or a spurious flag at that tick. A fault in the flag merge or the interrupt gating appears on `flags` or the interrupt lines at the same edge as the event or write, or one cycle after a mask change.

// File: rtl/timer16_pkg.sv
package timer16_pkg;

  // Mode codes formed as {mode_hi, mode_lo}
  localparam logic [3:0] MODE_FREE    = 4'd0;
  localparam logic [3:0] MODE_CLR_A   = 4'd4;
  localparam logic [3:0] MODE_CLR_CAP = 4'd12;

  // Event indices (internal order of the event vector)
  localparam int NUM_EV  = 5;
  localparam int EV_OVF  = 0;
  localparam int EV_CMPA = 1;
  localparam int EV_CMPB = 2;
  localparam int EV_CMPC = 3;
  localparam int EV_CAPT = 4;

  // Bit position of each event in the flag and mask bytes
  localparam int FLAG_POS [NUM_EV] = '{0, 1, 2, 3, 5};
  localparam logic [7:0] FLAG_IMPL = 8'h2F;

  // Number of plain compare channels
  localparam int NUM_CMP = 3;

  typedef enum logic [1:0] {
    TOP_FULL   = 2'd0,
    TOP_CMPA   = 2'd1,
    TOP_CAPREG = 2'd2
  } top_sel_e;

endpackage

// File: rtl/timer16_mode_dec.sv
module timer16_mode_dec
  import timer16_pkg::*;
(
  input  logic [1:0] mode_lo,
  input  logic [1:0] mode_hi,
  output logic       running,
  output top_sel_e   top_sel
);

  logic [3:0] mode;
  assign mode = {mode_hi, mode_lo};

  always_comb begin
    running = 1'b1;
    top_sel = TOP_FULL;
    case (mode)
      MODE_FREE:    top_sel = TOP_FULL;
      MODE_CLR_A:   top_sel = TOP_CMPA;
      MODE_CLR_CAP: top_sel = TOP_CAPREG;
      default:      running = 1'b0;
    endcase
  end

endmodule

// File: rtl/timer16_counter.sv
module timer16_counter
  import timer16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              running,
  input  top_sel_e          top_sel,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic [CNT_W-1:0]  cmp_c,
  input  logic [CNT_W-1:0]  cap_val,
  output logic [CNT_W-1:0]  count,
  output logic [NUM_EV-1:0] events
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             blocked;
  logic             advance;
  logic             live;
  logic [CNT_W-1:0] top_val;
  logic             at_top;
  logic [CNT_W-1:0] cmp_vals [NUM_CMP];
  logic [NUM_CMP-1:0] cmp_hit;

  assign cmp_vals[0] = cmp_a;
  assign cmp_vals[1] = cmp_b;
  assign cmp_vals[2] = cmp_c;

  // One equality comparator per compare channel
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign cmp_hit[g] = (count == cmp_vals[g]);
  end

  always_comb begin
    case (top_sel)
      TOP_CMPA:   top_val = cmp_a;
      TOP_CAPREG: top_val = cap_val;
      default:    top_val = CNT_MAX;
    endcase
  end

  assign at_top  = (count == top_val);
  assign advance = tick && running && !cnt_wr;
  assign live    = advance && !blocked;

  assign events[EV_OVF]  = live && (top_sel == TOP_FULL)   && at_top;
  assign events[EV_CMPA] = live && cmp_hit[0];
  assign events[EV_CMPB] = live && cmp_hit[1];
  assign events[EV_CMPC] = live && cmp_hit[2];
  assign events[EV_CAPT] = live && (top_sel == TOP_CAPREG) && at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (cnt_wr) begin
      count <= cnt_wdata;
    end else if (advance) begin
      if (at_top && !blocked) count <= '0;
      else                    count <= count + CNT_ONE;
    end
  end

  // Match suppression for the first counted tick after a write
  always_ff @(posedge clk) begin
    if (rst)                  blocked <= 1'b0;
    else if (cnt_wr)          blocked <= 1'b1;
    else if (tick && running) blocked <= 1'b0;
  end

endmodule

// File: rtl/timer16_flags.sv
module timer16_flags
  import timer16_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] events,
  input  logic [REG_W-1:0]  irq_mask,
  input  logic              flag_wr,
  input  logic [REG_W-1:0]  flag_wdata,
  output logic [REG_W-1:0]  flags,
  output logic [NUM_EV-1:0] irq
);

  localparam logic [REG_W-1:0] IMPL = REG_W'(FLAG_IMPL);

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] base;
  logic [REG_W-1:0] flags_nxt;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      set_vec[FLAG_POS[i]] = events[i];
    end
  end

  assign base      = flag_wr ? (flag_wdata & IMPL) : flags;
  assign flags_nxt = base | (set_vec & irq_mask & IMPL);

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= flags_nxt;
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_irq
    always_ff @(posedge clk) begin
      if (rst) irq[g] <= 1'b0;
      else     irq[g] <= flags_nxt[FLAG_POS[g]] & irq_mask[FLAG_POS[g]];
    end
  end

endmodule

// File: rtl/timer16_core.sv
module timer16_core
  import timer16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_off,
  input  logic             tick,
  input  logic [1:0]       mode_lo,
  input  logic [1:0]       mode_hi,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] cmp_c,
  input  logic [CNT_W-1:0] cap_val,
  input  logic [REG_W-1:0] irq_mask,
  input  logic             flag_wr,
  input  logic [REG_W-1:0] flag_wdata,
  output logic [CNT_W-1:0] count,
  output logic [REG_W-1:0] flags,
  output logic             irq_ovf,
  output logic             irq_cmpa,
  output logic             irq_cmpb,
  output logic             irq_cmpc,
  output logic             irq_capt
);

  logic              hold_rst;
  logic              running;
  top_sel_e          top_sel;
  logic [NUM_EV-1:0] events;
  logic [NUM_EV-1:0] irq;

  assign hold_rst = rst | pwr_off;

  timer16_mode_dec u_dec (
    .mode_lo (mode_lo),
    .mode_hi (mode_hi),
    .running (running),
    .top_sel (top_sel)
  );

  timer16_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (hold_rst),
    .tick      (tick),
    .running   (running),
    .top_sel   (top_sel),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .cmp_c     (cmp_c),
    .cap_val   (cap_val),
    .count     (count),
    .events    (events)
  );

  timer16_flags #(.REG_W(REG_W)) u_flg (
    .clk        (clk),
    .rst        (hold_rst),
    .events     (events),
    .irq_mask   (irq_mask),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .flags      (flags),
    .irq        (irq)
  );

  assign irq_ovf  = irq[EV_OVF];
  assign irq_cmpa = irq[EV_CMPA];
  assign irq_cmpb = irq[EV_CMPB];
  assign irq_cmpc = irq[EV_CMPC];
  assign irq_capt = irq[EV_CAPT];

endmodule

// File: rtl/timer16_core_chk.sv
module timer16_core_chk #(
  parameter int CNT_W = 16,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_off,
  input logic             tick,
  input logic [1:0]       mode_lo,
  input logic [1:0]       mode_hi,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cmp_a,
  input logic [CNT_W-1:0] cap_val,
  input logic [REG_W-1:0] irq_mask,
  input logic             flag_wr,
  input logic [CNT_W-1:0] count,
  input logic [REG_W-1:0] flags,
  input logic             irq_ovf,
  input logic             irq_cmpa,
  input logic             irq_cmpb,
  input logic             irq_cmpc,
  input logic             irq_capt
);

  logic [3:0] mode;
  logic       mode_ok;
  logic       chk_blk;

  assign mode    = {mode_hi, mode_lo};
  assign mode_ok = (mode == 4'd0) || (mode == 4'd4) || (mode == 4'd12);

  // Independent model of the post-write suppression window
  always_ff @(posedge clk) begin
    if (rst || pwr_off)       chk_blk <= 1'b0;
    else if (cnt_wr)          chk_blk <= 1'b1;
    else if (tick && mode_ok) chk_blk <= 1'b0;
  end

  p_pwr_clear_r1: assert property (@(posedge clk) disable iff (rst)
    pwr_off |=> (count == '0) && (flags == '0) &&
                !(irq_ovf || irq_cmpa || irq_cmpb || irq_cmpc || irq_capt));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr && !pwr_off) |=> $stable(count));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd0 && tick && !cnt_wr && !pwr_off && count != {CNT_W{1'b1}})
      |=> count == $past(count) + CNT_W'(1));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd0 && tick && !cnt_wr && !pwr_off && !chk_blk &&
     count == {CNT_W{1'b1}})
      |=> (count == '0) && (flags[0] || !$past(irq_mask[0])));

  p_clr_a_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd4 && tick && !cnt_wr && !pwr_off && !chk_blk &&
     count == cmp_a) |=> count == '0);

  p_clr_cap_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd12 && tick && !cnt_wr && !pwr_off && !chk_blk &&
     count == cap_val) |=> count == '0);

  p_gate_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    (!irq_mask[0] && !flag_wr) |=> !$rose(flags[0]));

  p_gate_capt_r7: assert property (@(posedge clk) disable iff (rst)
    (!irq_mask[5] && !flag_wr) |=> !$rose(flags[5]));

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    {irq_capt, irq_cmpc, irq_cmpb, irq_cmpa, irq_ovf} ==
    ({flags[5], flags[3:0]} & $past({irq_mask[5], irq_mask[3:0]})));

  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !pwr_off) |=> count == $past(cnt_wdata));

  p_halt_r10: assert property (@(posedge clk) disable iff (rst)
    (!mode_ok && !cnt_wr && !pwr_off) |=> $stable(count));

  p_unused_r11: assert property (@(posedge clk) disable iff (rst)
    (flags[4] == 1'b0) && (flags[7:6] == 2'b00));

endmodule

bind timer16_core timer16_core_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_off   (pwr_off),
  .tick      (tick),
  .mode_lo   (mode_lo),
  .mode_hi   (mode_hi),
  .cnt_wr    (cnt_wr),
  .cnt_wdata (cnt_wdata),
  .cmp_a     (cmp_a),
  .cap_val   (cap_val),
  .irq_mask  (irq_mask),
  .flag_wr   (flag_wr),
  .count     (count),
  .flags     (flags),
  .irq_ovf   (irq_ovf),
  .irq_cmpa  (irq_cmpa),
  .irq_cmpb  (irq_cmpb),
  .irq_cmpc  (irq_cmpc),
  .irq_capt  (irq_capt)
);

// File: tb/timer16_core_test.sv
module timer16_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_off = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  mode_lo = 2'd0;
  logic [1:0]  mode_hi = 2'd0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic [15:0] cmp_a = '0, cmp_b = '0, cmp_c = '0, cap_val = '0;
  logic [7:0]  irq_mask = '0;
  logic        flag_wr = 1'b0;
  logic [7:0]  flag_wdata = '0;
  logic [15:0] count;
  logic [7:0]  flags;
  logic        irq_ovf, irq_cmpa, irq_cmpb, irq_cmpc, irq_capt;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  timer16_core uut (
    .clk(clk), .rst(rst), .pwr_off(pwr_off), .tick(tick),
    .mode_lo(mode_lo), .mode_hi(mode_hi), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
    .cap_val(cap_val), .irq_mask(irq_mask), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .count(count), .flags(flags),
    .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb),
    .irq_cmpc(irq_cmpc), .irq_capt(irq_capt)
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] start;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [15:0] cc;
    logic [15:0] cap;
    logic [7:0]  mask;
    logic [7:0]  nticks;
    logic [15:0] ecnt;
    logic [7:0]  eflg;
  } vec_t;

  localparam int NV = 12;
  // Expected values worked out from the requirements; the first tick after
  // the preload write is always a suppressed one (R9).
  localparam vec_t VT [NV] = '{
    // R2 plain counting
    '{4'd0,  16'h0010, 16'h1000, 16'h1000, 16'h1000, 16'h0000, 8'h2F, 8'd5, 16'h0015, 8'h00},
    // R3 wrap with overflow flag
    '{4'd0,  16'hFFFD, 16'h1000, 16'h1000, 16'h1000, 16'h0000, 8'h01, 8'd4, 16'h0001, 8'h01},
    // R7 wrap with overflow masked
    '{4'd0,  16'hFFFD, 16'h1000, 16'h1000, 16'h1000, 16'h0000, 8'h00, 8'd4, 16'h0001, 8'h00},
    // R4 clear on compare A
    '{4'd4,  16'h0020, 16'h0022, 16'h1000, 16'h1000, 16'h0000, 8'h02, 8'd5, 16'h0002, 8'h02},
    // R5 clear on capture register
    '{4'd12, 16'h0030, 16'h1000, 16'h1000, 16'h1000, 16'h0032, 8'h20, 8'd4, 16'h0001, 8'h20},
    // R6 compare B and C in normal mode
    '{4'd0,  16'h0100, 16'h1000, 16'h0102, 16'h0103, 16'h0000, 8'h0C, 8'd6, 16'h0106, 8'h0C},
    // R12 three events on one tick
    '{4'd4,  16'h0040, 16'h0042, 16'h0042, 16'h0042, 16'h0000, 8'h0E, 8'd3, 16'h0000, 8'h0E},
    // R5 compare A inside a capture-TOP period
    '{4'd12, 16'h0050, 16'h0051, 16'h1000, 16'h1000, 16'h0053, 8'h22, 8'd5, 16'h0001, 8'h22},
    // R10 mode 1 halts
    '{4'd1,  16'h0070, 16'h0070, 16'h0070, 16'h0070, 16'h0070, 8'h2F, 8'd5, 16'h0070, 8'h00},
    // R10 mode 5 halts
    '{4'd5,  16'h0070, 16'h0070, 16'h0070, 16'h0070, 16'h0070, 8'h2F, 8'd5, 16'h0070, 8'h00},
    // R9 write equal to TOP in mode 4 skips the clear
    '{4'd4,  16'h0060, 16'h0060, 16'h1000, 16'h1000, 16'h0000, 8'h02, 8'd3, 16'h0063, 8'h00},
    // R9 write of all-ones in mode 0 skips the overflow flag
    '{4'd0,  16'hFFFF, 16'h1000, 16'h1000, 16'h1000, 16'h0000, 8'h01, 8'd2, 16'h0001, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
    end
  endtask

  function automatic logic [4:0] irq_of(input logic [7:0] f,
                                        input logic [7:0] m);
    logic [7:0] g;
    g = f & m;
    return {g[5], g[3], g[2], g[1], g[0]};
  endfunction

  logic [4:0] irq_now;
  assign irq_now = {irq_capt, irq_cmpc, irq_cmpb, irq_cmpa, irq_ovf};

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    check("R1 count after reset", 32'(count), 32'h0);
    check("R1 flags after reset", 32'(flags), 32'h0);
    check("R1 irq after reset", 32'(irq_now), 32'h0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      mode_lo   = VT[v].mode[1:0];
      mode_hi   = VT[v].mode[3:2];
      cmp_a     = VT[v].ca;
      cmp_b     = VT[v].cb;
      cmp_c     = VT[v].cc;
      cap_val   = VT[v].cap;
      irq_mask  = VT[v].mask;
      cnt_wr    = 1'b1;
      cnt_wdata = VT[v].start;
      flag_wr   = 1'b1;
      flag_wdata = 8'h00;
      step();
      cnt_wr  = 1'b0;
      flag_wr = 1'b0;
      do_ticks(int'(VT[v].nticks));
      check($sformatf("vector %0d count", v), 32'(count), 32'(VT[v].ecnt));
      check($sformatf("vector %0d flags", v), 32'(flags), 32'(VT[v].eflg));
      check($sformatf("R8 vector %0d irq", v), 32'(irq_now),
            32'(irq_of(VT[v].eflg, VT[v].mask)));
    end

    // R11 flag write replaces, unused bits stay 0; R8 irq follows at once
    mode_lo = 2'd0; mode_hi = 2'd0;
    irq_mask = 8'h2F;
    flag_wr = 1'b1; flag_wdata = 8'hFF;
    step();
    flag_wr = 1'b0;
    check("R11 flag write all ones", 32'(flags), 32'h2F);
    check("R8 irq all high", 32'(irq_now), 32'h1F);
    // R8 mask drop lowers lines one cycle later, flags kept
    irq_mask = 8'h00;
    step();
    check("R8 irq after mask drop", 32'(irq_now), 32'h0);
    check("R8 flags kept after mask drop", 32'(flags), 32'h2F);
    flag_wr = 1'b1; flag_wdata = 8'h00;
    step();
    flag_wr = 1'b0;
    check("R11 flag write zero", 32'(flags), 32'h0);

    // R11 event on the same edge as a flag write is ORed on top
    irq_mask = 8'h01;
    cmp_a = 16'h1000; cmp_b = 16'h1000; cmp_c = 16'h1000;
    cnt_wr = 1'b1; cnt_wdata = 16'hFFFE;
    step();
    cnt_wr = 1'b0;
    do_ticks(1);
    check("R9 suppressed tick still advances", 32'(count), 32'hFFFF);
    tick = 1'b1; flag_wr = 1'b1; flag_wdata = 8'h00;
    step();
    tick = 1'b0; flag_wr = 1'b0;
    check("R11 event over flag write", 32'(flags), 32'h01);
    check("R3 wrap count", 32'(count), 32'h0);

    // R9 write wins over a tick in the same cycle
    tick = 1'b1; cnt_wr = 1'b1; cnt_wdata = 16'h0200;
    step();
    tick = 1'b0; cnt_wr = 1'b0;
    check("R9 write beats tick", 32'(count), 32'h0200);
    // R2 no tick, count holds
    repeat (3) step();
    check("R2 hold without tick", 32'(count), 32'h0200);

    // R1 power-reduction clears and holds
    irq_mask = 8'h2F;
    flag_wr = 1'b1; flag_wdata = 8'h2F;
    step();
    flag_wr = 1'b0;
    pwr_off = 1'b1;
    do_ticks(3);
    check("R1 count under pwr_off", 32'(count), 32'h0);
    check("R1 flags under pwr_off", 32'(flags), 32'h0);
    check("R1 irq under pwr_off", 32'(irq_now), 32'h0);
    pwr_off = 1'b0;
    repeat (2) step();
    check("R1 count after pwr_off release", 32'(count), 32'h0);
    do_ticks(2);
    check("R2 count after release ticks", 32'(count), 32'h2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule